// File: doc/BRIEF.md
# LRU Stack Distance Profiler

This block watches the stream of block addresses presented to a set-associative cache and records, for every access, how deep in least-recently-used order the referenced block was found. Each set keeps its own recency list of tags, `ASSOC` entries deep. The most recently used tag sits at recency position 1 and the least recently used at position `ASSOC`. A hit at a given depth bumps that depth's counter and moves the tag to the front. An access whose tag is not in the list bumps a separate miss counter and pushes the tag in at the front. When the list is full, the oldest tag falls off the end.

Since LRU lists of every smaller associativity are prefixes of the full list, one profiling run gives the miss count of any cache with associativity up to `ASSOC`. The miss count for a smaller associativity is the miss counter plus every counter deeper than that associativity. The block computes that sum on request and presents it one cycle later. Any counter, including the miss counter, can also be read directly. Data storage is not modelled; only tags and valid bits are kept.

Top module: `lru_stack_profiler`

## Requirements
- R1: After reset every counter reads zero and `missOut` is zero. Every recency entry is invalid, so the first access to any block counts as a miss.
- R2: A hit at recency position i (1 = most recent, `ASSOC` = least recent) increments counter i and nothing else. Counter i is read on `rdCount` with `rdSel` = i-1 (combinational). The miss counter is read with `rdSel` = `ASSOC`. A `rdSel` above `ASSOC` reads zero. Counters change on the clock edge that samples `accValid` high.
- R3: On a hit at position i, the tag moves to position 1. The entries that were at positions 1 to i-1 each move one place deeper. Entries deeper than i are unchanged. A set never holds the same valid tag twice.
- R4: On a miss, the miss counter increments. Every entry moves one place deeper, the entry at position `ASSOC` is dropped, and the new tag enters at position 1.
- R5: The set index is `accAddr[OFFSET_W +: log2(NUM_SETS)]` and the tag is the bits above it. The offset bits below `OFFSET_W` have no effect. Each set has its own recency list, and an access to one set leaves the lists of all other sets unchanged.
- R6: One cycle after `qAssoc` = q, `missOut` equals the miss counter plus the counters of positions q+1 to `ASSOC`. The counters used are those present before that edge. For q >= `ASSOC` the result is the miss counter alone.
- R7: With `qAssoc` = 0, `missOut` equals the total number of counted accesses, which is the sum of all counters.
- R8: Counters are `CNT_W` bits wide (default 32) and hold at all-ones instead of wrapping. `missOut` also saturates at all-ones when the sum exceeds the range.
- R9: A high `clearCnt` zeroes every counter on that edge. An access in the same cycle still updates the recency lists but is not counted. The recency lists are never cleared by `clearCnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | ADDR_W | Byte address of the access |
| clearCnt | input | 1 | Zero all counters |
| rdSel | input | SEL_W | Counter select: 0..ASSOC-1 hit positions, ASSOC miss counter |
| rdCount | output | CNT_W | Selected counter value |
| qAssoc | input | SEL_W | Associativity asked for in the derived miss count |
| missOut | output | CNT_W | Derived miss count, registered |

## Verification
On every cycle the assertions check several properties. No set holds a tag twice, so at most one recency position matches. Counters stay still when nothing is presented, and a clear zeroes them. A miss advances the miss counter by exactly one unless it is saturated. A saturated counter stays saturated, and the derived count for the full associativity equals the previous miss counter. The bench's scenarios must show the rest. That covers the exact recency depth reached after each sequence of hits, misses and evictions, and the isolation between sets and the ignored offset bits. It also covers the derived sums for each smaller associativity, the total-access case, saturation of both a counter and the sum, and a clear that coincides with an access. These outcomes depend on the history of the recency lists, which no single-cycle property captures.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Strobes passed from control to the counter datapath and the stacks.
  typedef struct packed {
    logic stackUpdate;
    logic cntClear;
    logic bumpHit;
    logic bumpMiss;
  } lsdStrobes_t;

endpackage

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
  import lsd_pkg::*;
#(
  parameter int ASSOC = 4
) (
  input  logic             accValid,
  input  logic             clearCnt,
  input  logic [ASSOC-1:0] hitVec,
  output logic             lookupHit,
  output lsdStrobes_t      strb
);

  always_comb begin
    lookupHit        = |hitVec;
    strb.stackUpdate = accValid;
    strb.cntClear    = clearCnt;
    strb.bumpHit     = accValid && !clearCnt && lookupHit;
    strb.bumpMiss    = accValid && !clearCnt && !lookupHit;
  end

endmodule

// File: rtl/lsd_stack.sv
module lsd_stack #(
  parameter int NUM_SETS = 4,
  parameter int ASSOC    = 4,
  parameter int TAG_W    = 10,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int POS_W   = $clog2(ASSOC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic [TAG_W-1:0] tag,
  input  logic             update,
  input  logic             lookupHit,
  output logic [ASSOC-1:0] hitVec,
  output logic [POS_W-1:0] hitPos
);

  logic [TAG_W-1:0] tagMem   [NUM_SETS][ASSOC];
  logic [ASSOC-1:0] validMem [NUM_SETS];

  // Lookup across the recency list of the addressed set.
  always_comb begin
    for (int j = 0; j < ASSOC; j++) begin
      hitVec[j] = validMem[setIdx][j] && (tagMem[setIdx][j] == tag);
    end
  end

  always_comb begin
    hitPos = '0;
    for (int j = 0; j < ASSOC; j++) begin
      if (hitVec[j]) hitPos = POS_W'(j);
    end
  end

  // Shift enable per position: a miss shifts all, a hit shifts up to the hit depth.
  logic [ASSOC-1:0] shiftEn;
  always_comb begin
    for (int j = 0; j < ASSOC; j++) begin
      shiftEn[j] = !lookupHit || (POS_W'(j) <= hitPos);
    end
  end

  genvar s, w;
  generate
    for (s = 0; s < NUM_SETS; s++) begin : g_set
      logic setSel;
      assign setSel = update && (setIdx == SET_W'(s));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validMem[s] <= '0;
        end else if (setSel) begin
          validMem[s][0] <= 1'b1;
          for (int j = 1; j < ASSOC; j++) begin
            if (shiftEn[j]) validMem[s][j] <= validMem[s][j-1];
          end
        end
      end

      for (w = 0; w < ASSOC; w++) begin : g_way
        always_ff @(posedge clk) begin
          if (setSel) begin
            if (w == 0) begin
              tagMem[s][w] <= tag;
            end else if (shiftEn[w]) begin
              tagMem[s][w] <= tagMem[s][(w == 0) ? 0 : w-1];
            end
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lsd_counters.sv
module lsd_counters
  import lsd_pkg::*;
#(
  parameter int ASSOC    = 4,
  parameter int CNT_W    = 32,
  localparam int POS_W   = $clog2(ASSOC),
  localparam int SEL_W   = $clog2(ASSOC + 1),
  localparam int SUM_W   = CNT_W + $clog2(ASSOC + 2)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  lsdStrobes_t                strb,
  input  logic [POS_W-1:0]           hitPos,
  input  logic [SEL_W-1:0]           qAssoc,
  output logic [(ASSOC+1)*CNT_W-1:0] cntFlat,
  output logic [CNT_W-1:0]           missOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt [ASSOC+1];

  genvar k;
  generate
    for (k = 0; k <= ASSOC; k++) begin : g_cnt
      logic bump;
      if (k < ASSOC) begin : g_hit
        assign bump = strb.bumpHit && (hitPos == POS_W'(k));
      end else begin : g_miss
        assign bump = strb.bumpMiss;
      end

      always_ff @(posedge clk) begin
        if (!rstN || strb.cntClear) begin
          cnt[k] <= '0;
        end else if (bump && (cnt[k] != CNT_MAX)) begin
          cnt[k] <= cnt[k] + 1'b1;
        end
      end

      assign cntFlat[k*CNT_W +: CNT_W] = cnt[k];
    end
  endgenerate

  // Derived miss count: miss counter plus all positions deeper than qAssoc.
  logic [SUM_W-1:0] sumAcc;
  always_comb begin
    sumAcc = SUM_W'(cnt[ASSOC]);
    for (int j = 0; j < ASSOC; j++) begin
      if (j >= int'(qAssoc)) sumAcc = sumAcc + SUM_W'(cnt[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missOut <= '0;
    end else if (sumAcc > SUM_W'(CNT_MAX)) begin
      missOut <= CNT_MAX;
    end else begin
      missOut <= sumAcc[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/lru_stack_profiler.sv
module lru_stack_profiler
  import lsd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 4,
  parameter int NUM_SETS = 4,
  parameter int ASSOC    = 4,
  parameter int CNT_W    = 32,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - SET_W,
  localparam int POS_W   = $clog2(ASSOC),
  localparam int SEL_W   = $clog2(ASSOC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              clearCnt,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [CNT_W-1:0]  rdCount,
  input  logic [SEL_W-1:0]  qAssoc,
  output logic [CNT_W-1:0]  missOut
);

  logic [SET_W-1:0]           setIdx;
  logic [TAG_W-1:0]           tag;
  logic [OFFSET_W-1:0]        unusedOffset;
  logic [ASSOC-1:0]           hitVec;
  logic [POS_W-1:0]           hitPos;
  logic                       lookupHit;
  lsdStrobes_t                strb;
  logic [(ASSOC+1)*CNT_W-1:0] cntFlat;

  assign setIdx       = accAddr[OFFSET_W +: SET_W];
  assign tag          = accAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffset = accAddr[OFFSET_W-1:0];

  lsd_ctrl #(.ASSOC(ASSOC)) u_ctrl (
    .accValid (accValid),
    .clearCnt (clearCnt),
    .hitVec   (hitVec),
    .lookupHit(lookupHit),
    .strb     (strb)
  );

  lsd_stack #(.NUM_SETS(NUM_SETS), .ASSOC(ASSOC), .TAG_W(TAG_W)) u_stack (
    .clk      (clk),
    .rstN     (rstN),
    .setIdx   (setIdx),
    .tag      (tag),
    .update   (strb.stackUpdate),
    .lookupHit(lookupHit),
    .hitVec   (hitVec),
    .hitPos   (hitPos)
  );

  lsd_counters #(.ASSOC(ASSOC), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .hitPos (hitPos),
    .qAssoc (qAssoc),
    .cntFlat(cntFlat),
    .missOut(missOut)
  );

  always_comb begin
    if (rdSel <= SEL_W'(ASSOC)) rdCount = cntFlat[rdSel*CNT_W +: CNT_W];
    else                        rdCount = '0;
  end

endmodule

// File: rtl/lsd_checker.sv
module lsd_checker #(
  parameter int ASSOC = 4,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(ASSOC + 1)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       accValid,
  input logic                       clearCnt,
  input logic [SEL_W-1:0]           qAssoc,
  input logic [CNT_W-1:0]           missOut,
  input logic [ASSOC-1:0]           hitVec,
  input logic [(ASSOC+1)*CNT_W-1:0] cntFlat
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] missCnt;
  assign missCnt = cntFlat[ASSOC*CNT_W +: CNT_W];

  p_single_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid && !clearCnt) |=> $stable(cntFlat));

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    clearCnt |=> (cntFlat == '0));

  p_miss_bump_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !clearCnt && (hitVec == '0) && (missCnt != CNT_MAX))
      |=> (missCnt == $past(missCnt) + 1'b1));

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!clearCnt && (missCnt == CNT_MAX)) |=> (missCnt == CNT_MAX));

  p_full_assoc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (qAssoc >= SEL_W'(ASSOC)) |=> (missOut == $past(missCnt)));

endmodule

bind lru_stack_profiler lsd_checker #(.ASSOC(ASSOC), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .accValid(accValid),
  .clearCnt(clearCnt),
  .qAssoc  (qAssoc),
  .missOut (missOut),
  .hitVec  (hitVec),
  .cntFlat (cntFlat)
);

// File: tb/lru_stack_profiler_bench.sv
module lru_stack_profiler_bench;

  localparam int ADDR_W   = 16;
  localparam int OFFSET_W = 4;
  localparam int NUM_SETS = 4;
  localparam int ASSOC    = 4;
  localparam int CNT_W    = 12;
  localparam int SEL_W    = $clog2(ASSOC + 1);
  localparam int CMAX     = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic              clearCnt = 1'b0;
  logic [SEL_W-1:0]  rdSel = '0;
  logic [CNT_W-1:0]  rdCount;
  logic [SEL_W-1:0]  qAssoc = '0;
  logic [CNT_W-1:0]  missOut;

  lru_stack_profiler #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .NUM_SETS(NUM_SETS),
    .ASSOC(ASSOC), .CNT_W(CNT_W)
  ) u_lru_stack_profiler (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .clearCnt(clearCnt), .rdSel(rdSel), .rdCount(rdCount),
    .qAssoc(qAssoc), .missOut(missOut)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Reference model: per-set recency list, index 0 = most recent.
  int mTag [NUM_SETS][ASSOC];
  bit mVal [NUM_SETS][ASSOC];
  int mCnt [ASSOC+1];

  function automatic int satAdd(int a, int b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  function automatic int mkAddr(int tg, int st, int off);
    return (tg << (OFFSET_W + 2)) | (st << OFFSET_W) | off;
  endfunction

  function automatic int expDerived(int q);
    int s = mCnt[ASSOC];
    for (int p = q + 1; p <= ASSOC; p++) s += mCnt[p-1];
    return (s > CMAX) ? CMAX : s;
  endfunction

  task automatic modelAccess(int addr, bit counted);
    int st = (addr >> OFFSET_W) & (NUM_SETS - 1);
    int tg = addr >> (OFFSET_W + 2);
    int found = -1;
    for (int p = 0; p < ASSOC; p++)
      if (mVal[st][p] && mTag[st][p] == tg) found = p;
    if (counted) begin
      if (found >= 0) mCnt[found] = satAdd(mCnt[found], 1);
      else            mCnt[ASSOC] = satAdd(mCnt[ASSOC], 1);
    end
    // Remove found entry (or the last one on a miss), then push to the front.
    for (int p = (found >= 0 ? found : ASSOC - 1); p > 0; p--) begin
      mTag[st][p] = mTag[st][p-1];
      mVal[st][p] = mVal[st][p-1];
    end
    mTag[st][0] = tg;
    mVal[st][0] = 1'b1;
  endtask

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic access(int addr);
    accValid = 1'b1;
    accAddr  = ADDR_W'(addr);
    modelAccess(addr, 1'b1);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic readCnt(int sel, output int val);
    rdSel = SEL_W'(sel);
    #1;
    val = int'(rdCount);
  endtask

  task automatic compareAll(string req);
    int v;
    for (int k = 0; k <= ASSOC; k++) begin
      readCnt(k, v);
      check(req, v, mCnt[k], $sformatf("counter sel=%0d", k));
    end
  endtask

  task automatic checkDerived(string req, int q);
    qAssoc = SEL_W'(q);
    @(negedge clk);
    check(req, int'(missOut), expDerived(q), $sformatf("derived q=%0d", q));
  endtask

  task automatic clearCounters(bit withAccess, int addr);
    clearCnt = 1'b1;
    if (withAccess) begin
      accValid = 1'b1;
      accAddr  = ADDR_W'(addr);
      modelAccess(addr, 1'b0);
    end
    @(negedge clk);
    clearCnt = 1'b0;
    accValid = 1'b0;
    for (int k = 0; k <= ASSOC; k++) mCnt[k] = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    int a;
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < NUM_SETS; s++)
      for (int p = 0; p < ASSOC; p++) begin mVal[s][p] = 0; mTag[s][p] = 0; end
    for (int k = 0; k <= ASSOC; k++) mCnt[k] = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    compareAll("R1");
    check("R1", int'(missOut), 0, "missOut after reset");
    rstN = 1'b1;
    @(negedge clk);

    // R1/R4: five distinct tags into set 0 are all misses
    for (int t = 1; t <= 5; t++) access(mkAddr(t, 0, 0));
    compareAll("R4");
    check("R4", mCnt[ASSOC], 5, "model miss count");
    // tag 1 was dropped: miss again
    access(mkAddr(1, 0, 0));
    readCnt(ASSOC, v);
    check("R4", v, 6, "evicted tag misses");
    // stack now 1,5,4,3: tag 3 at position 4
    access(mkAddr(3, 0, 7));
    readCnt(3, v);
    check("R2", v, 1, "hit at deepest position");
    // stack 3,1,5,4: tag 5 at position 3 -> stack 5,3,1,4
    access(mkAddr(5, 0, 2));
    readCnt(2, v);
    check("R2", v, 1, "hit at position 3");
    // R3: tag 4 below the hit stayed at position 4
    access(mkAddr(4, 0, 0));
    readCnt(3, v);
    check("R3", v, 2, "untouched deeper entry still at position 4");
    // R5: offset bits ignored -> immediate hit at position 1
    access(mkAddr(4, 0, 15));
    readCnt(0, v);
    check("R5", v, 1, "offset change hits at position 1");
    // R5: same tag in another set is a miss, set 0 unaffected
    access(mkAddr(4, 2, 0));
    readCnt(ASSOC, v);
    check("R5", v, 7, "same tag other set misses");
    access(mkAddr(4, 0, 0));
    readCnt(0, v);
    check("R5", v, 2, "set 0 list unaffected by set 2");
    readCnt(ASSOC + 2, v);
    check("R2", v, 0, "out-of-range select reads zero");
    compareAll("R2");

    // R6/R7: derived counts for every associativity
    for (int q = 0; q <= ASSOC + 1; q++) checkDerived(q == 0 ? "R7" : "R6", q);

    // R9: clear with coincident access; list updated but not counted
    clearCounters(1'b1, mkAddr(9, 1, 0));
    compareAll("R9");
    access(mkAddr(9, 1, 0));
    readCnt(0, v);
    check("R9", v, 1, "uncounted access still entered the list");
    clearCounters(1'b0, 0);
    compareAll("R9");

    // Random phase over a small tag pool
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
      end else begin
        a = mkAddr($urandom_range(0, 6), $urandom_range(0, NUM_SETS - 1),
                   $urandom_range(0, 15));
        access(a);
      end
      if (n % 300 == 299) begin
        compareAll("R2");
        checkDerived("R6", $urandom_range(1, ASSOC - 1));
        checkDerived("R7", 0);
      end
    end

    // R8: saturation of a counter and of the derived sum
    clearCounters(1'b0, 0);
    for (int t = 20; t < 30; t++) access(mkAddr(t, 3, 0));
    for (int n = 0; n < CMAX + 20; n++) access(mkAddr(29, 3, 0));
    readCnt(0, v);
    check("R8", v, CMAX, "position 1 counter saturated");
    check("R8", mCnt[ASSOC], 10, "model miss count");
    compareAll("R8");
    checkDerived("R8", 0);
    check("R8", int'(missOut), CMAX, "derived total saturated");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule